// File: doc/BRIEF.md
# Master Clock Frame Timer with Slip Compensation

This block turns a free-running master clock into the timing that a voice-band converter needs: a clock enable at 256 kHz for the switched-capacitor filters and a clock enable once per 8 kHz frame. Three master clock rates are supported: 1.536 MHz, 1.544 MHz and 2.048 MHz. Every output is a one-cycle enable in the master clock domain, so downstream logic stays on one clock.

A single select pin does two jobs. When it sits at a static level, the encode bit clock serves both directions, and the level picks the divide ratio. When a bit clock toggles on the pin, the block drops back to separate bit clocks for the two directions and uses the 1.5 MHz ratio. A separate slip input marks a 1.544 MHz master clock. In that case each frame has 193 master cycles. One of them is absorbed as a hold cycle, so the ratio-6 chain still yields exactly 32 filter ticks and one frame tick per frame.

Top module: `mclk_frame_timer`

## Requirements
- R1: While `rst` is high, and in the first cycle after it is released, `tick_256k` and `tick_frame` are 0 and `bclk_shared` is 1. The frame counter starts at position 0.
- R2: With `sel_pin` held at 0 and `slip_en` at 0, `tick_256k` pulses at frame positions 5, 11, … (every 6th cycle). A frame is 192 cycles long. `tick_frame` is high in the last cycle of each frame, which is also the 32nd tick.
- R3: With `sel_pin` held static at 1, the ratio is 8. Ticks fall at positions 7, 15, …, a frame is 256 cycles long, and each frame holds 32 ticks.
- R4: With ratio 6 and `slip_en` at 1, a frame is 193 cycles long. Position 192 is a hold cycle: `tick_frame` is high there and `tick_256k` is low. The cycle before it carries the frame's 32nd tick.
- R5: `slip_en` has no effect while the ratio is 8. The frame stays 256 cycles long with ticks every 8 cycles.
- R6: Any change of `sel_pin` from one sampled cycle to the next marks the pin as a clock. `bclk_shared` goes to 0 in the following cycle, and the ratio is forced to 6.
- R7: Once `sel_pin` has not changed for `QUIET_WIN` (default 64) consecutive cycles after its last change, `bclk_shared` returns to 1. The ratio then follows the static level of the pin.
- R8: A change of the effective setting (ratio or slip) restarts the frame. The first cycle after the change is frame position 0, and no tick or frame pulse from the old setting follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_pin | input | 1 | Ratio select level, or the bit clock when toggling |
| slip_en | input | 1 | Marks a 1.544 MHz master clock (one hold cycle per frame) |
| tick_256k | output | 1 | One-cycle filter clock enable |
| tick_frame | output | 1 | One-cycle enable in the last cycle of each frame |
| bclk_shared | output | 1 | 1 when the encode bit clock serves both directions |

## Verification
The bench goes after the slip frame. A design that put the hold cycle in the wrong place, or let the prescaler run through it, would show a 33rd tick or a frame of 192 cycles. It also changes ratio and slip mid-frame: a design that did not restart would emit a stale tick or a frame pulse at the old spacing. Toggle bursts check that mode detection reacts in one cycle. They also check that the quiet window is counted exactly, because a window off by one moves the return to shared mode and the ratio switch by a cycle. Constrained-random segments mix slip settings with bursts and static levels, so that `slip_en` is shown to have no effect under ratio 8.

// File: rtl/mft_pkg.sv
package mft_pkg;

    // Effective divider setting: wide = ratio for the 2.048 MHz clock,
    // slip = one hold cycle per frame (1.544 MHz clock).
    typedef struct packed {
        logic wide;
        logic slip;
    } ratio_cfg_t;

    function automatic int unsigned ratio_div(ratio_cfg_t c, int unsigned dlo, int unsigned dhi);
        return c.wide ? dhi : dlo;
    endfunction

    function automatic int unsigned frame_cycles(ratio_cfg_t c, int unsigned dlo,
                                                 int unsigned dhi, int unsigned tpf);
        return ratio_div(c, dlo, dhi) * tpf + (c.slip ? 1 : 0);
    endfunction

endpackage

// File: rtl/mft_sel_detect.sv
module mft_sel_detect #(
    parameter int unsigned QUIET_WIN = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic sel_pin,
    output logic sel_level,
    output logic clocked
);
    localparam int unsigned CNT_W = (QUIET_WIN > 1) ? $clog2(QUIET_WIN) : 1;

    logic [CNT_W-1:0] quiet_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_level <= sel_pin;
            clocked   <= 1'b0;
            quiet_cnt <= '0;
        end else begin
            sel_level <= sel_pin;
            if (sel_pin != sel_level) begin
                clocked   <= 1'b1;
                quiet_cnt <= '0;
            end else if (clocked) begin
                if (quiet_cnt == CNT_W'(QUIET_WIN - 1)) begin
                    clocked   <= 1'b0;
                    quiet_cnt <= '0;
                end else begin
                    quiet_cnt <= quiet_cnt + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/mft_divider.sv
module mft_divider
    import mft_pkg::*;
#(
    parameter int unsigned DIV_LO = 6,
    parameter int unsigned DIV_HI = 8,
    parameter int unsigned TPF    = 32
) (
    input  logic       clk,
    input  logic       rst,
    input  ratio_cfg_t cfg_now,
    output ratio_cfg_t cfg_q,
    output logic       tick,
    output logic       frame_end
);
    localparam int unsigned MAX_LEN = DIV_HI * TPF + 1;
    localparam int unsigned CYC_W   = $clog2(MAX_LEN + 1);
    localparam int unsigned PRE_W   = (DIV_HI > 1) ? $clog2(DIV_HI) : 1;

    logic [CYC_W-1:0] cyc;
    logic [PRE_W-1:0] pre;
    logic [CYC_W-1:0] len_m1;
    logic [PRE_W-1:0] div_m1;
    logic             hold;

    always_comb begin
        len_m1    = CYC_W'(frame_cycles(cfg_q, DIV_LO, DIV_HI, TPF) - 1);
        div_m1    = PRE_W'(ratio_div(cfg_q, DIV_LO, DIV_HI) - 1);
        frame_end = (cyc == len_m1);
        hold      = cfg_q.slip && frame_end;
        tick      = !hold && (pre == div_m1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
            cyc   <= '0;
            pre   <= '0;
        end else if (cfg_now != cfg_q) begin
            cfg_q <= cfg_now;
            cyc   <= '0;
            pre   <= '0;
        end else begin
            cyc <= frame_end ? '0 : cyc + 1'b1;
            if (frame_end)
                pre <= '0;
            else if (!hold)
                pre <= (pre == div_m1) ? '0 : pre + 1'b1;
        end
    end

endmodule

// File: rtl/mclk_frame_timer.sv
module mclk_frame_timer
    import mft_pkg::*;
#(
    parameter int unsigned DIV_LO    = 6,
    parameter int unsigned DIV_HI    = 8,
    parameter int unsigned TPF       = 32,
    parameter int unsigned QUIET_WIN = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic sel_pin,
    input  logic slip_en,
    output logic tick_256k,
    output logic tick_frame,
    output logic bclk_shared
);
    logic       sel_level;
    logic       clocked;
    ratio_cfg_t cfg_now;
    ratio_cfg_t cfg_q;

    mft_sel_detect #(.QUIET_WIN(QUIET_WIN)) u_det (
        .clk      (clk),
        .rst      (rst),
        .sel_pin  (sel_pin),
        .sel_level(sel_level),
        .clocked  (clocked)
    );

    always_comb begin
        cfg_now.wide = !clocked && sel_level;
        cfg_now.slip = slip_en && !cfg_now.wide;
    end

    mft_divider #(.DIV_LO(DIV_LO), .DIV_HI(DIV_HI), .TPF(TPF)) u_div (
        .clk      (clk),
        .rst      (rst),
        .cfg_now  (cfg_now),
        .cfg_q    (cfg_q),
        .tick     (tick_256k),
        .frame_end(tick_frame)
    );

    assign bclk_shared = !clocked;

endmodule

// File: rtl/mft_checker.sv
module mft_checker
    import mft_pkg::*;
#(
    parameter int unsigned DIV_LO = 6,
    parameter int unsigned DIV_HI = 8,
    parameter int unsigned TPF    = 32
) (
    input logic       clk,
    input logic       rst,
    input logic       sel_pin,
    input logic       tick_256k,
    input logic       tick_frame,
    input logic       bclk_shared,
    input ratio_cfg_t cfg_q
);
    logic [15:0] gap;
    logic        span_valid;
    ratio_cfg_t  cfg_seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap        <= '0;
            span_valid <= 1'b0;
            cfg_seen   <= '0;
        end else begin
            cfg_seen <= cfg_q;
            gap      <= tick_frame ? 16'd0 : gap + 16'd1;
            if (cfg_q != cfg_seen)
                span_valid <= 1'b0;
            else if (tick_frame)
                span_valid <= 1'b1;
        end
    end

    // R8, also R2 R3 R4: spacing of frame pulses under an unchanged setting
    p_frame_span_r8: assert property (@(posedge clk) disable iff (rst)
        (tick_frame && span_valid && cfg_q == cfg_seen) |->
            (gap == 16'(frame_cycles(cfg_q, DIV_LO, DIV_HI, TPF) - 1)));

    p_frame_on_tick_r2: assert property (@(posedge clk) disable iff (rst)
        (tick_frame && !cfg_q.slip) |-> tick_256k);

    p_slip_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (tick_frame && cfg_q.slip) |-> (!tick_256k && $past(tick_256k)));

    p_toggle_clocked_r6: assert property (@(posedge clk) disable iff (rst)
        !$stable(sel_pin) |=> !bclk_shared);

endmodule

bind mclk_frame_timer mft_checker #(
    .DIV_LO(DIV_LO), .DIV_HI(DIV_HI), .TPF(TPF)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .sel_pin    (sel_pin),
    .tick_256k  (tick_256k),
    .tick_frame (tick_frame),
    .bclk_shared(bclk_shared),
    .cfg_q      (cfg_q)
);

// File: tb/sim_mclk_frame_timer.sv
module sim_mclk_frame_timer;
    localparam int DLO = 6, DHI = 8, TPF = 32, WIN = 64;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sel_pin = 1'b0;
    logic slip_en = 1'b0;
    logic tick_256k, tick_frame, bclk_shared;

    int total = 0;
    int bad = 0;
    bit finished = 0;
    bit live = 0;

    always #5 clk = ~clk;

    mclk_frame_timer #(.DIV_LO(DLO), .DIV_HI(DHI), .TPF(TPF), .QUIET_WIN(WIN)) u0 (
        .clk(clk), .rst(rst), .sel_pin(sel_pin), .slip_en(slip_en),
        .tick_256k(tick_256k), .tick_frame(tick_frame), .bclk_shared(bclk_shared)
    );

    // Expected-state tracking derived from R1..R8
    bit m_prev, m_clk, m_wide, m_slip;
    int m_quiet, m_cyc, m_since, m_ticks;

    function automatic int exp_len(bit w, bit s);
        return (w ? DHI : DLO) * TPF + (s ? 1 : 0);
    endfunction

    function automatic bit exp_tick(int cyc, bit w);
        int d = w ? DHI : DLO;
        return (cyc < d * TPF) && (cyc % d == d - 1);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_prev = sel_pin; m_clk = 0; m_quiet = 0;
            m_wide = 0; m_slip = 0; m_cyc = 0; m_since = 0;
        end else begin
            bit nw, ns;
            nw = !m_clk && m_prev;
            ns = slip_en && !nw;
            if (nw != m_wide || ns != m_slip) begin
                m_wide = nw; m_slip = ns; m_cyc = 0; m_since = 0;
            end else begin
                m_cyc = (m_cyc == exp_len(m_wide, m_slip) - 1) ? 0 : m_cyc + 1;
                m_since++;
            end
            if (sel_pin != m_prev) begin
                m_clk = 1; m_quiet = 0;
            end else if (m_clk) begin
                if (m_quiet == WIN - 1) begin m_clk = 0; m_quiet = 0; end
                else m_quiet++;
            end
            m_prev = sel_pin;
        end
    end

    task automatic chk(bit got, bit exp, string tag, string what);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0b expected=%0b at %0t", tag, what, got, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst) begin
            if (live) begin
                chk(tick_256k, 1'b0, "R1", "tick in reset");
                chk(tick_frame, 1'b0, "R1", "frame in reset");
                chk(bclk_shared, 1'b1, "R1", "shared in reset");
            end
        end else if (live) begin
            string tag;
            int len;
            len = exp_len(m_wide, m_slip);
            if (m_since < len) tag = "R8";
            else if (m_wide) tag = slip_en ? "R5" : "R3";
            else tag = m_slip ? "R4" : "R2";
            chk(tick_256k, exp_tick(m_cyc, m_wide), tag, "tick_256k");
            chk(tick_frame, m_cyc == len - 1, tag, "tick_frame");
            chk(bclk_shared, !m_clk, m_clk ? "R6" : "R7", "bclk_shared");
            if (m_cyc == 0) m_ticks = 0;
            if (tick_256k) m_ticks++;
            if (m_cyc == len - 1 && m_since >= len - 1) begin
                total++;
                if (m_ticks != TPF) begin
                    bad++;
                    $display("FAIL %s ticks per frame: actual=%0d expected=%0d", tag, m_ticks, TPF);
                end
            end
        end
    end

    task automatic run(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic burst(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if ($urandom_range(0, 2) != 0) sel_pin = ~sel_pin;
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        void'($urandom(32'h1544));
        live = 1;
        run(3);
        rst = 1'b0;                            // R1: first cycle after release
        run(600);                              // R2
        sel_pin = 1'b1; run(800);              // R3 with R8 restart
        sel_pin = 1'b0; slip_en = 1'b1;
        run(WIN + 700);                        // R6 single change, R7 return, R4
        sel_pin = 1'b1; run(WIN + 700);        // R5: slip under ratio 8
        burst(400);                            // R6 toggling
        run(WIN - 1);                          // R7 boundary, one short of the window
        run(400);
        for (int k = 0; k < 12; k++) begin
            slip_en = 1'($urandom_range(0, 1));
            if ($urandom_range(0, 3) == 0) burst(int'($urandom_range(5, 90)));
            else sel_pin = 1'($urandom_range(0, 1));
            run(int'($urandom_range(50, 700)));
        end
        rst = 1'b1; run(3); rst = 1'b0;        // R1 again, with the state now dirty
        run(300);
        summary();
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=timeout expected=done");
            summary();
        end
    end

endmodule